// File: doc/BRIEF.md
# Message-Triggered Interrupt Source Controller

This block is the source stage of a two-level priority interrupt controller. It holds a table of interrupt sources. Each entry carries a target server index, an 8-bit priority, a "bounced" flag and a "held while masked" flag. Message or edge triggers arrive by local table index. An unmasked source is offered downstream as a global source number, a server index and a priority. The downstream presentation stage can bounce an offer back by naming its global number. It can also ask for a resend, which walks the whole table one entry per clock and offers every bounced source again.

Priority 0xFF masks a source. A trigger on a masked source is not lost: the source remains held until a configuration write gives it a real priority, and that write offers it at once. A configuration port reads and writes an entry's server and priority, checks its arguments and answers with a status word. An end-of-interrupt pulse is accepted and changes nothing.

Offers leave through a single valid/ready slot. Every event that would need an offer waits, through its own ready signal or by stalling the scan, until that slot can take it, so none is dropped.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every entry reads back with server 0 and priority 0xFF, with both flags clear. No offer is pending, `busy` is low and `cfg_done` is low.
- R2: Global source numbers are `BASE` plus the table index. A configuration access whose number lies outside `BASE` to `BASE+NUM_SRC-1` answers status 0xFFFFFFFD (-3) and changes nothing.
- R3: A configuration write whose server is at or above `NUM_SERVERS`, or whose priority exceeds 0xFF, answers 0xFFFFFFFD and leaves the entry unchanged.
- R4: An accepted configuration access raises `cfg_done` for exactly the next cycle, with status 0 on success. A successful read also returns the stored server and priority, zero-extended.
- R5: A trigger on an unmasked source produces one offer carrying `BASE+index`, the entry's server and its priority.
- R6: A trigger on a masked source (priority 0xFF) produces no offer and sets its held flag. A later write with a priority other than 0xFF offers the source at once, with the new server and priority, and clears the flag.
- R7: A write that keeps priority 0xFF leaves the held flag set and produces no offer. A write to a source without the held flag produces no offer.
- R8: A bounce naming an in-range number sets that entry's bounced flag, and an out-of-range number is ignored. A resend offers every bounced, unmasked source in ascending index order and clears the flags, so an immediate second resend offers nothing.
- R9: A bounced source that is masked when the scan reaches it loses its bounced flag without an offer. Unmasking it later does not offer it.
- R10: `busy` is high exactly while a scan runs: `NUM_SRC` cycles when the output never stalls. Triggers and configuration accesses are held off with their ready signals low meanwhile.
- R11: While `off_valid` is high and `off_ready` is low, the offer payload holds steady. Offers leave in the order of the events that caused them, and none is lost under back-pressure.
- R12: An end-of-interrupt pulse produces no offer and changes no table state. This includes the held flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request |
| trig_src | input | IW | Local table index of the triggered source |
| trig_ready | output | 1 | Trigger accepted this cycle when high with trig_valid |
| rej_valid | input | 1 | Bounce from the presentation stage |
| rej_num | input | 24 | Global number of the bounced source |
| resend_req | input | 1 | Request one full-table resend scan |
| eoi_valid | input | 1 | End-of-interrupt notification (no effect) |
| cfg_valid | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_num | input | 32 | Global source number |
| cfg_server | input | 32 | Server index to write |
| cfg_prio | input | 32 | Priority to write |
| cfg_ready | output | 1 | Configuration access accepted when high with cfg_valid |
| cfg_done | output | 1 | Response valid, one cycle after acceptance |
| cfg_status | output | 32 | 0 on success, 0xFFFFFFFD on bad argument |
| cfg_rd_server | output | 32 | Server returned by a successful read |
| cfg_rd_prio | output | 8 | Priority returned by a successful read |
| busy | output | 1 | Resend scan in progress |
| off_valid | output | 1 | Offer valid |
| off_ready | input | 1 | Presentation stage takes the offer |
| off_num | output | 24 | Global source number of the offer |
| off_server | output | SW | Target server of the offer |
| off_prio | output | 8 | Priority of the offer |

## Verification
A wrong held flag is silent until the masked source is rewritten. It then shows up as a missing or extra offer on the cycle after that write. A wrong bounced flag is silent until the next resend, when the scan produces an offer out of order or misses one. Configuration state errors appear on `cfg_rd_server`/`cfg_rd_prio` one cycle after a read is accepted, and in the payload of the next offer from that entry. The bench therefore ends with a full read-back of the table and a final resend, so that no corrupted entry escapes unobserved.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam logic [7:0]  PRIO_MASKED = 8'hFF;
  localparam logic [31:0] ST_OK       = 32'h0000_0000;
  localparam logic [31:0] ST_BAD_ARG  = 32'hFFFF_FFFD;
  localparam int          GNUM_W      = 24;

  function automatic logic num_in_range(input logic [31:0] num,
                                        input logic [31:0] base,
                                        input logic [31:0] count);
    return (num >= base) && ((num - base) < count);
  endfunction

  function automatic logic idx_in_table(input logic [31:0] idx,
                                        input logic [31:0] count);
    return idx < count;
  endfunction

  function automatic logic [GNUM_W-1:0] glob_num(input logic [31:0] base,
                                                 input logic [31:0] idx);
    return GNUM_W'(base + idx);
  endfunction

  function automatic logic is_masked(input logic [7:0] prio);
    return prio == PRIO_MASKED;
  endfunction

endpackage

// File: rtl/src_table.sv
module src_table #(
  parameter int NUM_SRC = 1024,
  parameter int IW      = 10,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [SW-1:0] wr_srv,
  input  logic [7:0]    wr_prio,
  input  logic          rej_set,
  input  logic [IW-1:0] rej_set_idx,
  input  logic          rej_clr,
  input  logic [IW-1:0] rej_clr_idx,
  input  logic          hold_set,
  input  logic [IW-1:0] hold_set_idx,
  input  logic          hold_clr,
  input  logic [IW-1:0] hold_clr_idx,
  input  logic [IW-1:0] a_idx,
  output logic [7:0]    a_prio,
  output logic [SW-1:0] a_srv,
  output logic          a_hold,
  input  logic [IW-1:0] b_idx,
  output logic [7:0]    b_prio,
  output logic [SW-1:0] b_srv,
  output logic          b_rej
);

  logic [7:0]       prio_q [NUM_SRC];
  logic [SW-1:0]    srv_q  [NUM_SRC];
  logic [NUM_SRC-1:0] rej_q;
  logic [NUM_SRC-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= 8'hFF;
        srv_q[i]  <= '0;
      end
    end else if (wr_en) begin
      prio_q[wr_idx] <= wr_prio;
      srv_q[wr_idx]  <= wr_srv;
    end
  end

  // Set is applied after clear: a bounce landing on the entry being
  // scanned keeps the flag for the following resend.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_q <= '0;
    end else begin
      if (rej_clr) rej_q[rej_clr_idx] <= 1'b0;
      if (rej_set) rej_q[rej_set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      if (hold_clr) hold_q[hold_clr_idx] <= 1'b0;
      if (hold_set) hold_q[hold_set_idx] <= 1'b1;
    end
  end

  assign a_prio = prio_q[a_idx];
  assign a_srv  = srv_q[a_idx];
  assign a_hold = hold_q[a_idx];
  assign b_prio = prio_q[b_idx];
  assign b_srv  = srv_q[b_idx];
  assign b_rej  = rej_q[b_idx];

endmodule

// File: rtl/resend_scanner.sv
module resend_scanner #(
  parameter int NUM_SRC = 1024,
  parameter int IW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          advance,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          start,
  output logic          done
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_SRC - 1);

  logic          pend_q;
  logic          busy_q;
  logic [IW-1:0] idx_q;

  assign start = !busy_q && pend_q;
  assign done  = busy_q && advance && (idx_q == LAST_IDX);
  assign busy  = busy_q;
  assign idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      pend_q <= (pend_q && !start) || req;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q && advance) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/offer_slot.sv
module offer_slot #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [23:0]   ld_num,
  input  logic [SW-1:0] ld_srv,
  input  logic [7:0]    ld_prio,
  input  logic          ready,
  output logic          valid,
  output logic [23:0]   num,
  output logic [SW-1:0] srv,
  output logic [7:0]    prio,
  output logic          free
);

  logic valid_q;

  assign free  = !valid_q || ready;
  assign valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num     <= '0;
      srv     <= '0;
      prio    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      num     <= ld_num;
      srv     <= ld_srv;
      prio    <= ld_prio;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC     = 1024,
  parameter int NUM_SERVERS = 16,
  parameter int BASE        = 4096,
  localparam int IW = $clog2(NUM_SRC),
  localparam int SW = $clog2(NUM_SERVERS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_valid,
  input  logic [IW-1:0] trig_src,
  output logic          trig_ready,
  input  logic          rej_valid,
  input  logic [23:0]   rej_num,
  input  logic          resend_req,
  input  logic          eoi_valid,
  input  logic          cfg_valid,
  input  logic          cfg_write,
  input  logic [31:0]   cfg_num,
  input  logic [31:0]   cfg_server,
  input  logic [31:0]   cfg_prio,
  output logic          cfg_ready,
  output logic          cfg_done,
  output logic [31:0]   cfg_status,
  output logic [31:0]   cfg_rd_server,
  output logic [7:0]    cfg_rd_prio,
  output logic          busy,
  output logic          off_valid,
  input  logic          off_ready,
  output logic [23:0]   off_num,
  output logic [SW-1:0] off_server,
  output logic [7:0]    off_prio
);

  localparam logic [31:0] BASE32 = 32'(BASE);
  localparam logic [31:0] NSRC32 = 32'(NUM_SRC);
  localparam logic [31:0] NSRV32 = 32'(NUM_SERVERS);

  // Named internal events, also observed by the bound checker.
  logic          slot_free;
  logic          scan_start, scan_done, scan_advance, scan_clear;
  logic [IW-1:0] scan_idx;
  logic          cfg_fire, trig_fire;
  logic          ev_trig_offer, ev_trig_hold, ev_unmask_offer, ev_scan_offer, ev_rej;
  logic          eoi_seen;

  logic [IW-1:0] a_idx, cfg_idx, rej_idx;
  logic [7:0]    a_prio, b_prio;
  logic [SW-1:0] a_srv, b_srv;
  logic          a_hold, b_rej;

  logic          trig_ok, num_ok, srv_ok, prio_ok, wr_ok, rd_ok;
  logic [7:0]    new_prio;
  logic [SW-1:0] new_srv;

  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic [SW-1:0] ld_srv;
  logic [7:0]    ld_prio;

  // Argument decode
  assign cfg_idx  = IW'(cfg_num - BASE32);
  assign rej_idx  = IW'(32'(rej_num) - BASE32);
  assign num_ok   = num_in_range(cfg_num, BASE32, NSRC32);
  assign srv_ok   = cfg_server < NSRV32;
  assign prio_ok  = cfg_prio <= 32'h0000_00FF;
  assign wr_ok    = cfg_write && num_ok && srv_ok && prio_ok;
  assign rd_ok    = !cfg_write && num_ok;
  assign new_prio = cfg_prio[7:0];
  assign new_srv  = SW'(cfg_server);
  assign trig_ok  = idx_in_table(32'(trig_src), NSRC32);

  // Arbitration: scan owns the table while busy; otherwise config
  // wins over trigger. Both wait for the offer slot.
  assign cfg_ready  = !busy && slot_free;
  assign trig_ready = !busy && slot_free && !cfg_valid;
  assign cfg_fire   = cfg_valid && cfg_ready;
  assign trig_fire  = trig_valid && trig_ready;
  assign a_idx      = cfg_valid ? cfg_idx : trig_src;

  assign ev_trig_offer   = trig_fire && trig_ok && !is_masked(a_prio);
  assign ev_trig_hold    = trig_fire && trig_ok &&  is_masked(a_prio);
  assign ev_unmask_offer = cfg_fire && wr_ok && a_hold && !is_masked(new_prio);
  assign ev_rej          = rej_valid && num_in_range(32'(rej_num), BASE32, NSRC32);
  assign eoi_seen        = eoi_valid;

  // Scan step: a bounced unmasked entry needs the slot; others pass.
  assign ev_scan_offer = busy && b_rej && !is_masked(b_prio) && slot_free;
  assign scan_advance  = busy && (!b_rej || is_masked(b_prio) || slot_free);
  assign scan_clear    = busy && b_rej && scan_advance;

  always_comb begin
    ld_en   = 1'b0;
    ld_idx  = '0;
    ld_srv  = '0;
    ld_prio = '0;
    if (ev_scan_offer) begin
      ld_en = 1'b1; ld_idx = scan_idx; ld_srv = b_srv; ld_prio = b_prio;
    end else if (ev_unmask_offer) begin
      ld_en = 1'b1; ld_idx = cfg_idx; ld_srv = new_srv; ld_prio = new_prio;
    end else if (ev_trig_offer) begin
      ld_en = 1'b1; ld_idx = trig_src; ld_srv = a_srv; ld_prio = a_prio;
    end
  end

  src_table #(.NUM_SRC(NUM_SRC), .IW(IW), .SW(SW)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_fire && wr_ok),
    .wr_idx       (cfg_idx),
    .wr_srv       (new_srv),
    .wr_prio      (new_prio),
    .rej_set      (ev_rej),
    .rej_set_idx  (rej_idx),
    .rej_clr      (scan_clear),
    .rej_clr_idx  (scan_idx),
    .hold_set     (ev_trig_hold),
    .hold_set_idx (trig_src),
    .hold_clr     (ev_unmask_offer),
    .hold_clr_idx (cfg_idx),
    .a_idx        (a_idx),
    .a_prio       (a_prio),
    .a_srv        (a_srv),
    .a_hold       (a_hold),
    .b_idx        (scan_idx),
    .b_prio       (b_prio),
    .b_srv        (b_srv),
    .b_rej        (b_rej)
  );

  resend_scanner #(.NUM_SRC(NUM_SRC), .IW(IW)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (resend_req),
    .advance (scan_advance),
    .busy    (busy),
    .idx     (scan_idx),
    .start   (scan_start),
    .done    (scan_done)
  );

  offer_slot #(.SW(SW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld_en),
    .ld_num  (glob_num(BASE32, 32'(ld_idx))),
    .ld_srv  (ld_srv),
    .ld_prio (ld_prio),
    .ready   (off_ready),
    .valid   (off_valid),
    .num     (off_num),
    .srv     (off_server),
    .prio    (off_prio),
    .free    (slot_free)
  );

  // Configuration response, one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_done      <= 1'b0;
      cfg_status    <= ST_OK;
      cfg_rd_server <= '0;
      cfg_rd_prio   <= '0;
    end else begin
      cfg_done <= cfg_fire;
      if (cfg_fire) begin
        cfg_status    <= (cfg_write ? wr_ok : rd_ok) ? ST_OK : ST_BAD_ARG;
        cfg_rd_server <= rd_ok ? 32'(a_srv) : 32'h0;
        cfg_rd_prio   <= rd_ok ? a_prio : 8'h00;
      end
    end
  end

endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk #(
  parameter int NUM_SRC = 1024,
  parameter int BASE    = 4096,
  parameter int SW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cfg_ready,
  input logic          trig_ready,
  input logic          cfg_valid,
  input logic          cfg_done,
  input logic [31:0]   cfg_status,
  input logic          off_valid,
  input logic          off_ready,
  input logic [23:0]   off_num,
  input logic [SW-1:0] off_server,
  input logic [7:0]    off_prio,
  input logic          scan_start,
  input logic          scan_done,
  input logic          trig_fire,
  input logic          cfg_fire,
  input logic          ev_trig_offer,
  input logic          ev_unmask_offer,
  input logic          eoi_seen
);

  // R11
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid && !off_ready |=> off_valid && $stable(off_num) &&
                                $stable(off_server) && $stable(off_prio));

  // R2
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> (32'(off_num) >= 32'(BASE)) &&
                  (32'(off_num) < 32'(BASE) + 32'(NUM_SRC)));

  // R5
  trig_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trig_offer |=> off_valid && (off_prio != 8'hFF));

  // R6
  unmask_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unmask_offer |=> off_valid && (off_prio != 8'hFF));

  // R4
  cfg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> cfg_done);

  // R4
  cfg_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(cfg_fire));

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (cfg_status == 32'h0) || (cfg_status == 32'hFFFF_FFFD));

  // R10
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cfg_ready && !trig_ready);

  // R10
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> busy);

  // R10
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !busy);

  // R12
  eoi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_seen && !busy && !trig_fire && !cfg_fire && !off_valid |=> !off_valid);

endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .BASE    (BASE),
  .SW      (SW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (busy),
  .cfg_ready       (cfg_ready),
  .trig_ready      (trig_ready),
  .cfg_valid       (cfg_valid),
  .cfg_done        (cfg_done),
  .cfg_status      (cfg_status),
  .off_valid       (off_valid),
  .off_ready       (off_ready),
  .off_num         (off_num),
  .off_server      (off_server),
  .off_prio        (off_prio),
  .scan_start      (scan_start),
  .scan_done       (scan_done),
  .trig_fire       (trig_fire),
  .cfg_fire        (cfg_fire),
  .ev_trig_offer   (ev_trig_offer),
  .ev_unmask_offer (ev_unmask_offer),
  .eoi_seen        (eoi_seen)
);

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;

  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int S     = 4;
  localparam int BASE  = 32;
  localparam int IW    = $clog2(N);
  localparam int SW    = $clog2(S);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_valid = 1'b0;
  logic [IW-1:0] trig_src = '0;
  logic          trig_ready;
  logic          rej_valid = 1'b0;
  logic [23:0]   rej_num = '0;
  logic          resend_req = 1'b0;
  logic          eoi_valid = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_write = 1'b0;
  logic [31:0]   cfg_num = '0, cfg_server = '0, cfg_prio = '0;
  logic          cfg_ready, cfg_done;
  logic [31:0]   cfg_status, cfg_rd_server;
  logic [7:0]    cfg_rd_prio;
  logic          busy, off_valid;
  logic          off_ready = 1'b1;
  logic [23:0]   off_num;
  logic [SW-1:0] off_server;
  logic [7:0]    off_prio;

  irq_source_ctrl #(.NUM_SRC(N), .NUM_SERVERS(S), .BASE(BASE)) i_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .rej_valid(rej_valid), .rej_num(rej_num), .resend_req(resend_req),
    .eoi_valid(eoi_valid),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_ready(cfg_ready),
    .cfg_done(cfg_done), .cfg_status(cfg_status),
    .cfg_rd_server(cfg_rd_server), .cfg_rd_prio(cfg_rd_prio),
    .busy(busy), .off_valid(off_valid), .off_ready(off_ready),
    .off_num(off_num), .off_server(off_server), .off_prio(off_prio)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R5";
  bit stall_en = 1'b0;
  bit done_flag = 1'b0;

  int m_prio [N];
  int m_srv  [N];
  bit m_rej  [N];
  bit m_hold [N];
  logic [39:0] exp_q [$];

  function automatic logic [31:0] exp_status(bit wr, logic [31:0] num, logic [31:0] srv, logic [31:0] pr);
    bit ok = (num >= BASE) && (num < BASE + N);
    if (wr) ok = ok && (srv < S) && (pr <= 255);
    return ok ? 32'h0 : 32'hFFFF_FFFD;
  endfunction

  function automatic logic [39:0] pack_offer(int idx, int srv, int pr);
    return {24'(BASE + idx), 8'(srv), 8'(pr)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Offer monitor: a transfer happens at the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && off_valid && off_ready) begin
        logic [39:0] got;
        got = {off_num, 8'(off_server), off_prio};
        if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected offer", got, 0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk(got == e, cur_req, "offer payload", got, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      off_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  task automatic trig(int idx);
    @(negedge clk);
    trig_valid = 1'b1; trig_src = IW'(idx);
    forever begin
      #(CLK_P/4);
      if (trig_ready) break;
      @(negedge clk);
    end
    if (m_prio[idx] == 255) m_hold[idx] = 1'b1;
    else exp_q.push_back(pack_offer(idx, m_srv[idx], m_prio[idx]));
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic cfg(bit wr, logic [31:0] num, logic [31:0] srv, logic [31:0] pr, string req);
    logic [31:0] es;
    int idx;
    es = exp_status(wr, num, srv, pr);
    idx = int'(num) - BASE;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = wr; cfg_num = num; cfg_server = srv; cfg_prio = pr;
    forever begin
      #(CLK_P/4);
      if (cfg_ready) break;
      @(negedge clk);
    end
    if (wr && es == 0) begin
      m_srv[idx] = int'(srv); m_prio[idx] = int'(pr);
      if (m_hold[idx] && pr != 255) begin
        m_hold[idx] = 1'b0;
        exp_q.push_back(pack_offer(idx, int'(srv), int'(pr)));
      end
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    #(CLK_P/4);
    chk(cfg_done == 1'b1, "R4", "cfg_done", cfg_done, 1);
    chk(cfg_status == es, req, "cfg_status", cfg_status, es);
    if (!wr && es == 0) begin
      chk(cfg_rd_server == 32'(m_srv[idx]), req, "read server", cfg_rd_server, m_srv[idx]);
      chk(cfg_rd_prio == 8'(m_prio[idx]), req, "read prio", cfg_rd_prio, m_prio[idx]);
    end
  endtask

  task automatic reject(int num);
    @(negedge clk);
    rej_valid = 1'b1; rej_num = 24'(num);
    if (num >= BASE && num < BASE + N) m_rej[num - BASE] = 1'b1;
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic resend(output int busy_cycles, output bit gate_ok);
    busy_cycles = 0; gate_ok = 1'b1;
    @(negedge clk);
    resend_req = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (m_rej[i]) begin
        m_rej[i] = 1'b0;
        if (m_prio[i] != 255) exp_q.push_back(pack_offer(i, m_srv[i], m_prio[i]));
      end
    end
    @(negedge clk);
    resend_req = 1'b0;
    forever begin
      #(CLK_P/4);
      if (busy) break;
      @(negedge clk);
    end
    forever begin
      if (!busy) break;
      busy_cycles++;
      if (cfg_ready || trig_ready) gate_ok = 1'b0;
      @(negedge clk);
      #(CLK_P/4);
    end
  endtask

  task automatic drain(string req);
    int t = 0;
    while ((exp_q.size() != 0 || off_valid) && t < 200) begin
      @(negedge clk); #(CLK_P/4); t++;
    end
    chk(exp_q.size() == 0, req, "pending expected offers", exp_q.size(), 0);
  endtask

  initial begin
    int bc;
    bit gok;
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 255; m_srv[i] = 0; m_rej[i] = 0; m_hold[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    // R1 reset outputs
    chk(!off_valid, "R1", "off_valid", off_valid, 0);
    chk(!busy, "R1", "busy", busy, 0);
    chk(!cfg_done, "R1", "cfg_done", cfg_done, 0);
    cur_req = "R1";
    cfg(0, BASE + 3, 0, 0, "R1");
    cfg(0, BASE + N - 1, 0, 0, "R1");
    resend(bc, gok);
    drain("R1");

    // R2 range
    cfg(0, BASE - 1, 0, 0, "R2");
    cfg(0, BASE + N, 0, 0, "R2");
    cfg(1, BASE + N, 1, 8'h10, "R2");
    cfg(0, BASE, 0, 0, "R2");

    // R3 argument checks
    cfg(1, BASE + 4, S, 8'h10, "R3");
    cfg(1, BASE + 4, 1, 32'h100, "R3");
    cfg(0, BASE + 4, 0, 0, "R3");

    // R5 plain trigger
    cur_req = "R5";
    cfg(1, BASE + 5, 2, 8'h10, "R5");
    trig(5);
    drain("R5");

    // R6 held then unmasked
    cur_req = "R6";
    trig(7);
    cfg(1, BASE + 7, 1, 8'h20, "R6");
    cfg(1, BASE + 7, 1, 8'h30, "R6");
    drain("R6");

    // R7 write keeping mask
    cur_req = "R7";
    trig(8);
    cfg(1, BASE + 8, 3, 8'hFF, "R7");
    cfg(0, BASE + 8, 0, 0, "R7");
    cfg(1, BASE + 8, 3, 8'h05, "R7");
    drain("R7");

    // R8 bounce and resend order
    cur_req = "R8";
    cfg(1, BASE + 1, 1, 8'h11, "R8");
    cfg(1, BASE + 3, 2, 8'h33, "R8");
    reject(BASE + 3);
    reject(BASE + 1);
    reject(BASE + N);
    resend(bc, gok);
    drain("R8");
    // R10 scan length and gating with an unstalled output
    chk(bc == N, "R10", "busy cycles", bc, N);
    chk(gok, "R10", "ready low while busy", gok, 1);
    resend(bc, gok);
    drain("R8");

    // R9 bounced then masked
    cur_req = "R9";
    cfg(1, BASE + 2, 0, 8'h22, "R9");
    reject(BASE + 2);
    cfg(1, BASE + 2, 0, 8'hFF, "R9");
    resend(bc, gok);
    cfg(1, BASE + 2, 0, 8'h40, "R9");
    drain("R9");

    // R12 end-of-interrupt leaves held flag and table alone
    cur_req = "R12";
    trig(9);
    @(negedge clk); eoi_valid = 1'b1;
    @(negedge clk); eoi_valid = 1'b0;
    cfg(0, BASE + 9, 0, 0, "R12");
    drain("R12");
    cfg(1, BASE + 9, 2, 8'h09, "R12");
    drain("R12");

    // R11 back-pressure with random mix
    cur_req = "R11";
    stall_en = 1'b1;
    for (int i = 0; i < N; i++) if (m_prio[i] == 255) cfg(1, BASE + i, i % S, 8'(i * 7 + 1), "R11");
    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: trig(int'($urandom % N));
        1: cfg(1, BASE - 1 + ($urandom % (N + 2)), $urandom % (S + 1),
               (($urandom % 5) == 0) ? 32'hFF : (($urandom % 9) == 0 ? 32'h100 : $urandom % 256), "R11");
        2: cfg(0, BASE - 1 + ($urandom % (N + 2)), 0, 0, "R4");
        3: reject(BASE - 2 + int'($urandom % (N + 4)));
        4: resend(bc, gok);
        default: begin
          @(negedge clk); eoi_valid = 1'b1;
          @(negedge clk); eoi_valid = 1'b0;
        end
      endcase
    end
    drain("R11");
    stall_en = 1'b0;

    // Final sweep: every entry read back, then outstanding bounces flushed
    cur_req = "R8";
    for (int i = 0; i < N; i++) cfg(0, BASE + i, 0, 0, "R4");
    resend(bc, gok);
    drain("R8");

    done_flag = 1'b1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end

endmodule